// File: doc/BRIEF.md
# Super-Pixel Hit Readout Node

This block is one link of a readout chain running down a double column of a pixel matrix. It serves a group of eight pixels, four rows by two columns. Hit pulses from the eight discriminators are collected into a pattern register. The group's arrival-time counter is stopped until the first hit of a window arrives, and then advances on every tick of a clock enable that stands in for the group's local oscillator. The tick rate is set by whatever drives that enable.

A pulse on the window-end input closes the integration window. If any pixel was hit, the node then freezes a 22-bit packet holding the group position, the elapsed tick count and the hit pattern. The node sends that packet toward the bottom of the column over a four-phase request/acknowledge link. It also accepts packets from the node above it on an identical link and passes them on unchanged. When both kinds of packet are waiting, the packet from above wins. Hits that arrive while the local packet is waiting to be sent are kept for the following window. The pattern and the counter are cleared only once the node below has acknowledged the local packet.

Top module: `sp_readout_node`

## Requirements
- R1: After reset, `dn_req`, `up_ack` and `dn_data` are all zero.
- R2: A local packet has this layout: bits [21:18] are the group address parameter `GRP_ADDR`, bits [17:8] are the tick count, and bits [7:0] are the hit pattern. Bit i of the pattern is 1 when `pix_hit[i]` was high in any cycle of the window.
- R3: The counter stays at zero until a hit has been latched. It then adds one at each rising edge where `tick_en` is high. Counting begins at the edge after the edge that latched the first hit and ends with the edge that samples `frame_rst`, which is included.
- R4: The tick count saturates at 1023.
- R5: A `frame_rst` pulse in a window with no hits produces no packet.
- R6: On the downstream link, `dn_data` holds steady while `dn_req` is high. `dn_req` falls after `dn_ack` rises, and it does not rise again while `dn_ack` is still high.
- R7: An upstream packet is forwarded bit for bit. `up_ack` rises to accept it, stays high while `up_req` stays high, and falls in the cycle after `up_req` falls.
- R8: When an upstream request and a local packet are both waiting while the downstream link is idle, the upstream packet is sent first.
- R9: Hits that arrive after the local packet has been frozen go into the next window's pattern and are absent from the frozen packet. A `frame_rst` that arrives while the local packet is still waiting has no effect.
- R10: The counter returns to zero when the local packet is acknowledged, so the next window's count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_hit | input | 8 | Hit pulses, one per pixel of the group |
| frame_rst | input | 1 | Closes the integration window |
| tick_en | input | 1 | Oscillator tick, used as the counter enable |
| up_req | input | 1 | Request from the node above |
| up_data | input | 22 | Packet from the node above |
| up_ack | output | 1 | Acknowledge to the node above |
| dn_req | output | 1 | Request to the node below |
| dn_data | output | 22 | Packet to the node below |
| dn_ack | input | 1 | Acknowledge from the node below |

## Verification
Hit patterns on different pixels, arriving in different cycles, show whether the pattern bits are ORed per pixel. Gapped tick patterns separate counting every cycle from counting only on enabled edges. Three timing cases pin down both ends of the counting interval and the ceiling: a window closed right after its first hit, a run of ticks before any hit, and a very long window. A slow downstream acknowledge is used in two ways. In one, an upstream packet and a local packet pile up behind it, which exposes the arbitration order. In the other, late hits and a stray window-end pulse arrive while the local packet waits, which shows whether the pattern is frozen and whether it is cleared only on acknowledge.

// File: rtl/sp_node_pkg.sv
package sp_node_pkg;

  localparam int ADDR_W_D = 4;
  localparam int CNT_W_D  = 10;
  localparam int HIT_W_D  = 8;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_SEND  = 2'd1,
    OUT_DRAIN = 2'd2
  } out_state_e;

  typedef enum logic {
    SRC_LOCAL = 1'b0,
    SRC_UP    = 1'b1
  } pkt_src_e;

  // packet = {address, count, hits}, address in the top bits
  function automatic logic [ADDR_W_D+CNT_W_D+HIT_W_D-1:0] pkt_pack(
      input logic [ADDR_W_D-1:0] addr,
      input logic [CNT_W_D-1:0]  cnt,
      input logic [HIT_W_D-1:0]  hits);
    return {addr, cnt, hits};
  endfunction

  // one saturating tick
  function automatic logic [CNT_W_D-1:0] cnt_step(
      input logic [CNT_W_D-1:0] cnt,
      input logic               en);
    if (en && (cnt != {CNT_W_D{1'b1}}))
      return cnt + 1'b1;
    return cnt;
  endfunction

endpackage

// File: rtl/sp_hit_latch.sv
module sp_hit_latch #(
  parameter int HIT_W = sp_node_pkg::HIT_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HIT_W-1:0] pix_hit,
  input  logic             frame_rst,
  input  logic             loc_done,
  output logic [HIT_W-1:0] hit_q,
  output logic             loc_pend,
  output logic             capture,
  output logic             run
);

  logic [HIT_W-1:0] next_q;

  assign capture = frame_rst && (hit_q != '0) && !loc_pend;
  assign run     = (hit_q != '0) && !loc_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q    <= '0;
      next_q   <= '0;
      loc_pend <= 1'b0;
    end else if (loc_done) begin
      hit_q    <= next_q | pix_hit;
      next_q   <= '0;
      loc_pend <= 1'b0;
    end else if (capture) begin
      loc_pend <= 1'b1;
      next_q   <= pix_hit;
    end else if (loc_pend) begin
      next_q   <= next_q | pix_hit;
    end else begin
      hit_q    <= hit_q | pix_hit;
    end
  end

  // R9
  frozen_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_pend && !loc_done) |=> $stable(hit_q));

endmodule

// File: rtl/sp_time_counter.sv
module sp_time_counter #(
  parameter int CNT_W = sp_node_pkg::CNT_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);

  import sp_node_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (clear)
      cnt <= '0;
    else
      cnt <= cnt_step(cnt, run && tick_en);
  end

  // R4
  cnt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == {CNT_W{1'b1}}) && !clear) |=> (cnt == {CNT_W{1'b1}}));

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(cnt));

endmodule

// File: rtl/sp_chain_arbiter.sv
module sp_chain_arbiter #(
  parameter int PKT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loc_pend,
  input  logic [PKT_W-1:0] loc_pkt,
  input  logic             up_req,
  input  logic [PKT_W-1:0] up_data,
  output logic             up_ack,
  output logic             dn_req,
  output logic [PKT_W-1:0] dn_data,
  input  logic             dn_ack,
  output logic             loc_done
);

  import sp_node_pkg::*;

  out_state_e       state;
  pkt_src_e         src;
  logic             up_ack_q;
  logic [PKT_W-1:0] data_q;
  logic             link_free;
  logic             take_up;
  logic             take_loc;

  assign link_free = (state == OUT_IDLE) && !dn_ack;
  assign take_up   = link_free && up_req && !up_ack_q;
  assign take_loc  = link_free && !take_up && loc_pend;
  assign loc_done  = (state == OUT_SEND) && dn_ack && (src == SRC_LOCAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= OUT_IDLE;
      src    <= SRC_LOCAL;
      data_q <= '0;
    end else begin
      case (state)
        OUT_IDLE: begin
          if (take_up) begin
            state  <= OUT_SEND;
            src    <= SRC_UP;
            data_q <= up_data;
          end else if (take_loc) begin
            state  <= OUT_SEND;
            src    <= SRC_LOCAL;
            data_q <= loc_pkt;
          end
        end
        OUT_SEND:  if (dn_ack)  state <= OUT_DRAIN;
        OUT_DRAIN: if (!dn_ack) state <= OUT_IDLE;
        default:   state <= OUT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      up_ack_q <= 1'b0;
    else if (take_up)
      up_ack_q <= 1'b1;
    else if (!up_req)
      up_ack_q <= 1'b0;
  end

  assign up_ack  = up_ack_q;
  assign dn_req  = (state == OUT_SEND);
  assign dn_data = data_q;

  // R6
  dn_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |=> (!dn_req || $stable(dn_data)));

  // R6
  dn_req_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_req && dn_ack) |=> !dn_req);

  // R7
  up_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ack && up_req) |=> up_ack);

  // R8
  up_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_req && !dn_ack && up_req && !up_ack && loc_pend) |=> (!dn_req || up_ack));

endmodule

// File: rtl/sp_readout_node.sv
module sp_readout_node #(
  parameter int ADDR_W   = sp_node_pkg::ADDR_W_D,
  parameter int CNT_W    = sp_node_pkg::CNT_W_D,
  parameter int HIT_W    = sp_node_pkg::HIT_W_D,
  parameter int GRP_ADDR = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [HIT_W-1:0]                pix_hit,
  input  logic                            frame_rst,
  input  logic                            tick_en,
  input  logic                            up_req,
  input  logic [ADDR_W+CNT_W+HIT_W-1:0]   up_data,
  output logic                            up_ack,
  output logic                            dn_req,
  output logic [ADDR_W+CNT_W+HIT_W-1:0]   dn_data,
  input  logic                            dn_ack
);

  import sp_node_pkg::*;

  localparam int PKT_W = ADDR_W + CNT_W + HIT_W;
  localparam logic [ADDR_W-1:0] ADDR_V = ADDR_W'(GRP_ADDR);

  logic [HIT_W-1:0] hit_q;
  logic [CNT_W-1:0] cnt;
  logic             loc_pend;
  logic             capture;
  logic             run;
  logic             loc_done;
  logic [PKT_W-1:0] loc_pkt;

  sp_hit_latch #(.HIT_W(HIT_W)) u_hits (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_hit  (pix_hit),
    .frame_rst(frame_rst),
    .loc_done (loc_done),
    .hit_q    (hit_q),
    .loc_pend (loc_pend),
    .capture  (capture),
    .run      (run)
  );

  sp_time_counter #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick_en(tick_en),
    .clear  (loc_done),
    .cnt    (cnt)
  );

  // field layout depends on the widths; the package helper covers the default
  generate
    if ((ADDR_W == ADDR_W_D) && (CNT_W == CNT_W_D) && (HIT_W == HIT_W_D)) begin : g_pack_pkg
      assign loc_pkt = pkt_pack(ADDR_V, cnt, hit_q);
    end else begin : g_pack_gen
      assign loc_pkt = {ADDR_V, cnt, hit_q};
    end
  endgenerate

  sp_chain_arbiter #(.PKT_W(PKT_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .loc_pend(loc_pend),
    .loc_pkt (loc_pkt),
    .up_req  (up_req),
    .up_data (up_data),
    .up_ack  (up_ack),
    .dn_req  (dn_req),
    .dn_data (dn_data),
    .dn_ack  (dn_ack),
    .loc_done(loc_done)
  );

  // R5
  pend_has_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_pend |-> (hit_q != '0));

  // R2
  capture_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> loc_pend);

endmodule

// File: tb/sim_sp_readout_node.sv
module sim_sp_readout_node;

  localparam int GA = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pix_hit = '0;
  logic        frame_rst = 1'b0;
  logic        tick_en = 1'b0;
  logic        up_req = 1'b0;
  logic [21:0] up_data = '0;
  logic        up_ack;
  logic        dn_req;
  logic [21:0] dn_data;
  logic        dn_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int ack_delay = 2;
  int rx_count = 0;
  bit mon_busy = 1'b0;

  logic [21:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  sp_readout_node #(.GRP_ADDR(GA)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_hit(pix_hit), .frame_rst(frame_rst),
    .tick_en(tick_en), .up_req(up_req), .up_data(up_data), .up_ack(up_ack),
    .dn_req(dn_req), .dn_data(dn_data), .dn_ack(dn_ack)
  );

  function automatic logic [21:0] mk(input int c, input logic [7:0] h);
    return (22'(GA) << 18) | (22'(c) << 8) | 22'(h);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic expect_pkt(input logic [21:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // drive one cycle starting at a negedge, end at the next negedge
  task automatic step(input logic [7:0] pix, input bit tk, input bit fr);
    pix_hit = pix; tick_en = tk; frame_rst = fr;
    @(negedge clk);
    pix_hit = '0; frame_rst = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 3) begin
      step(8'h00, 1'b0, 1'b0);
      if (exp_q.size() == 0 && !dn_req && !dn_ack && !mon_busy) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic up_send(input logic [21:0] v);
    up_data = v; up_req = 1'b1;
    do @(negedge clk); while (!up_ack);
    up_req = 1'b0;
    @(negedge clk);
    check(up_ack == 1'b0, "R7 up_ack release", 32'(up_ack), 32'h0);
  endtask

  // scoreboard monitor / downstream receiver
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dn_req && !dn_ack) begin
        logic [21:0] e;
        string t;
        bit stable;
        mon_busy = 1'b1;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected packet", 32'(dn_data), 32'h0);
          e = dn_data; t = "none";
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(dn_data == e, t, 32'(dn_data), 32'(e));
        end
        stable = 1'b1;
        for (int k = 0; k < ack_delay; k++) begin
          @(negedge clk);
          if (!dn_req || dn_data != e) stable = 1'b0;
        end
        check(stable, "R6 data held while requesting", 32'(dn_data), 32'(e));
        dn_ack = 1'b1;
        while (dn_req) @(negedge clk);
        dn_ack = 1'b0;
        rx_count++;
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6 act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ticks;
    int rx0;
    repeat (3) @(negedge clk);
    check(dn_req == 1'b0, "R1 dn_req reset", 32'(dn_req), 32'h0);
    check(up_ack == 1'b0, "R1 up_ack reset", 32'(up_ack), 32'h0);
    check(dn_data == '0, "R1 dn_data reset", 32'(dn_data), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: two pixels hit at different times, gapped ticks
    ack_delay = 2;
    ticks = 0;
    step(8'h08, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      bit tk;
      tk = (i % 3) != 0;
      ticks += int'(tk);
      step((i == 7) ? 8'h40 : 8'h00, tk, 1'b0);
    end
    ticks += 1;
    expect_pkt(mk(ticks, 8'h48), "R2 R3 gapped ticks, two pixels");
    step(8'h00, 1'b1, 1'b1);
    wait_idle();

    // R3: ticks before any hit are not counted; first count is at the window-end edge
    repeat (50) step(8'h00, 1'b1, 1'b0);
    step(8'h80, 1'b1, 1'b0);
    expect_pkt(mk(1, 8'h80), "R3 idle before first hit");
    step(8'h00, 1'b1, 1'b1);
    wait_idle();

    // R4: saturation
    step(8'h01, 1'b0, 1'b0);
    repeat (1100) step(8'h00, 1'b1, 1'b0);
    expect_pkt(mk(1023, 8'h01), "R4 count saturates");
    step(8'h00, 1'b1, 1'b1);
    wait_idle();

    // R5: empty window produces nothing
    rx0 = rx_count;
    step(8'h00, 1'b1, 1'b1);
    repeat (20) step(8'h00, 1'b1, 1'b0);
    check(rx_count == rx0 && !dn_req, "R5 empty window silent", 32'(rx_count), 32'(rx0));

    // R7: plain relay
    expect_pkt(22'h2A5C3E, "R7 relay unchanged");
    up_send(22'h2A5C3E);
    wait_idle();

    // R8: upstream and local both waiting behind a slow acknowledge
    ack_delay = 30;
    expect_pkt(22'h13579B, "R8 first upstream");
    fork up_send(22'h13579B); join_none
    repeat (3) step(8'h00, 1'b0, 1'b0);
    step(8'h11, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b1);
    expect_pkt(22'h0BEEF1, "R8 upstream before local");
    expect_pkt(mk(0, 8'h11), "R8 local after upstream");
    fork up_send(22'h0BEEF1); join_none
    wait_idle();

    // R9 / R10: late hits and stray window end while the local packet waits
    ack_delay = 20;
    step(8'h01, 1'b0, 1'b0);
    repeat (5) step(8'h00, 1'b1, 1'b0);
    expect_pkt(mk(6, 8'h01), "R9 frozen packet excludes late hit");
    step(8'h00, 1'b1, 1'b1);
    repeat (3) step(8'h00, 1'b1, 1'b0);
    step(8'h20, 1'b1, 1'b0);
    step(8'h00, 1'b1, 1'b0);
    step(8'h00, 1'b1, 1'b1);
    wait_idle();
    check(exp_q.size() == 0 && !dn_req, "R9 stray window end ignored", 32'(exp_q.size()), 32'h0);
    expect_pkt(mk(0, 8'h20), "R10 R9 next window, cleared count");
    step(8'h00, 1'b0, 1'b1);
    wait_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule